// File: doc/BRIEF.md
# Interleaved Burst Interface Checker

This block watches a channelized packet interface of the kind that feeds a multi-lane packet transmitter. It never drives the interface and is fully synthesizable.

On each clock it samples the following fields:
- an 8-bit channel number;
- a count of valid 64-bit words, from 0 to 4. The 256-bit symbol holds four words, most significant word first.
- burst start and burst end flags;
- a packet start flag;
- a 4-bit end-of-packet code. Bit 3 of the code is the end flag and bits 2:0 are a word field. The code 4'b1011 marks an end with only the two upper words valid. The code 4'b0000 means no end.

The checker does not need the data words themselves.

Packets on different channels may interleave at burst granularity. A channel's packet can pause at the end of a burst and resume in a later burst, after bursts from other channels. The checker keeps one bit per channel that records whether that channel has a packet open. A query port reads that bit.

When a rule is broken, the checker sets a sticky flag for that rule. It also latches a 3-bit cause code for the first violation. Both stay set until a synchronous clear pulse.

Top module: `burst_iface_checker`

## Requirements
- R1: After reset, err_flags and err_cause are zero and q_open reads 0 for every channel.
- R2: A cycle with nonzero word count, outside an open burst and without burst start, sets err_flags[0] (cause 1).
- R3: A cycle with zero word count that asserts burst start, burst end or packet start, or that carries a nonzero end code, sets err_flags[1] (cause 2).
- R4: A data cycle with packet start must carry a count of 4. So must the cycle right after a data cycle that has packet start and no end flag. Otherwise err_flags[2] is set (cause 3).
- R5: A data cycle whose end code has bit 3 set but that lacks burst end sets err_flags[3] (cause 4).
- R6: While a burst is open, a data cycle on a different channel, or one with burst start, sets err_flags[4] (cause 5).
- R7: A data cycle with packet start on a channel that already has a packet open sets err_flags[5] (cause 6).
- R8: A data cycle with end bit 3 set and no packet start, on a channel with no open packet, sets err_flags[6] (cause 7).
- R9: A data cycle with packet start opens its channel, and one with end bit 3 closes it. When both appear in the same cycle, the channel is left closed. q_open shows the new state one cycle later.
- R10: Flags accumulate until cleared. err_cause takes the lowest cause number among the violations of the first violating cycle, and later violations do not change it.
- R11: A cycle with clr high leaves err_flags and err_cause at zero in the next cycle, and any violation in that same cycle is discarded. The channel table is not affected.
- R12: Interleaved legal traffic sets no flag. An example is channel A opening a packet in one burst, channel B completing a whole packet, then A resuming and ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of flags and cause |
| in_chan | input | 8 | Channel number of the current symbol |
| in_nvalid | input | 3 | Count of valid 64-bit words |
| in_sob | input | 1 | Burst start |
| in_eob | input | 1 | Burst end |
| in_sop | input | 1 | Packet start |
| in_eopcode | input | 4 | End code: bit 3 end flag, bits 2:0 word field |
| q_chan | input | 8 | Channel whose open bit is read |
| q_open | output | 1 | 1 when q_chan has a packet open |
| err_flags | output | 7 | Sticky violation flags, bit k-1 for cause k |
| err_cause | output | 3 | Cause of the first violation, 0 when none |

## Verification
The properties assume that clr is held low in the cycle before the violation they check. They also assume that q_chan follows the channel just written when the table is checked. The stimulus keeps clr as a one-cycle pulse on an idle cycle, except in the case that deliberately pairs clr with a violation. Every scenario closes its open bursts and packets before the next scenario begins, so no flag carries over from one case into another unintentionally.

// File: rtl/bic_pkg.sv
package bic_pkg;
    localparam int NUM_CAUSE = 7;

    typedef enum logic [2:0] {
        CZ_NONE   = 3'd0,
        CZ_STRAY  = 3'd1,
        CZ_EMPTY  = 3'd2,
        CZ_SOPW   = 3'd3,
        CZ_NOEOB  = 3'd4,
        CZ_SWITCH = 3'd5,
        CZ_REOPEN = 3'd6,
        CZ_ORPHAN = 3'd7
    } cause_e;
endpackage

// File: rtl/bic_burst_track.sv
module bic_burst_track #(
    parameter int CHAN_W = 8,
    parameter int NV_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic [NV_W-1:0]   in_nvalid,
    input  logic              in_sob,
    input  logic              in_eob,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              burst_open,
    output logic [CHAN_W-1:0] burst_chan,
    output logic              sop_prev
);
    typedef struct packed {
        logic              bopen;
        logic [CHAN_W-1:0] bchan;
        logic              sopp;
    } trk_t;

    trk_t st_d, st_q;
    logic active;

    always_comb begin
        active = (in_nvalid != '0);
        st_d   = st_q;
        if (active && in_sob) begin
            st_d.bopen = 1'b1;
            st_d.bchan = in_chan;
        end
        if (active && in_eob) begin
            st_d.bopen = 1'b0;
        end
        st_d.sopp = active && in_sop && !in_eop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign burst_open = st_q.bopen;
    assign burst_chan = st_q.bchan;
    assign sop_prev   = st_q.sopp;
endmodule

// File: rtl/bic_chan_table.sv
module bic_chan_table #(
    parameter int CHAN_W = 8,
    localparam int NUM_CH = 1 << CHAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [CHAN_W-1:0] rd_chan,
    output logic              rd_open,
    input  logic [CHAN_W-1:0] q_chan,
    output logic              q_open
);
    logic [NUM_CH-1:0] open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (set_en) open_d[wr_chan] = 1'b1;
        if (clr_en) open_d[wr_chan] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= '0;
        else        open_q <= open_d;
    end

    assign rd_open = open_q[rd_chan];
    assign q_open  = open_q[q_chan];
endmodule

// File: rtl/bic_rules.sv
module bic_rules
    import bic_pkg::*;
#(
    parameter int CHAN_W = 8,
    parameter int NV_W   = 3,
    parameter int FULL   = 4
) (
    input  logic [CHAN_W-1:0]    in_chan,
    input  logic [NV_W-1:0]      in_nvalid,
    input  logic                 in_sob,
    input  logic                 in_eob,
    input  logic                 in_sop,
    input  logic [3:0]           in_eopcode,
    input  logic                 burst_open,
    input  logic [CHAN_W-1:0]    burst_chan,
    input  logic                 sop_prev,
    input  logic                 chan_open,
    output logic [NUM_CAUSE-1:0] viol
);
    logic active, full, eop;

    always_comb begin
        active = (in_nvalid != '0);
        full   = (in_nvalid == NV_W'(FULL));
        eop    = in_eopcode[3];
        viol   = '0;
        viol[CZ_STRAY-1]  = active && !burst_open && !in_sob;
        viol[CZ_EMPTY-1]  = !active && (in_sob || in_eob || in_sop || (in_eopcode != 4'd0));
        viol[CZ_SOPW-1]   = (active && in_sop && !full) || (sop_prev && !full);
        viol[CZ_NOEOB-1]  = active && eop && !in_eob;
        viol[CZ_SWITCH-1] = active && burst_open && (in_sob || (in_chan != burst_chan));
        viol[CZ_REOPEN-1] = active && in_sop && chan_open;
        viol[CZ_ORPHAN-1] = active && eop && !in_sop && !chan_open;
    end
endmodule

// File: rtl/bic_err_log.sv
module bic_err_log
    import bic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [NUM_CAUSE-1:0] viol,
    output logic [NUM_CAUSE-1:0] err_flags,
    output logic [2:0]           err_cause
);
    typedef struct packed {
        logic [NUM_CAUSE-1:0] flags;
        logic [2:0]           cause;
    } log_t;

    log_t lg_d, lg_q;
    logic [2:0] first;

    always_comb begin
        first = '0;
        for (int k = NUM_CAUSE; k >= 1; k--) begin
            if (viol[k-1]) first = 3'(k);
        end
        lg_d = lg_q;
        if (clr) begin
            lg_d = '0;
        end else begin
            lg_d.flags = lg_q.flags | viol;
            if (lg_q.cause == 3'd0) lg_d.cause = first;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lg_q <= '0;
        else        lg_q <= lg_d;
    end

    assign err_flags = lg_q.flags;
    assign err_cause = lg_q.cause;
endmodule

// File: rtl/burst_iface_checker.sv
module burst_iface_checker
    import bic_pkg::*;
#(
    parameter int CHAN_W = 8,
    parameter int WORDS  = 4,
    localparam int NV_W  = $clog2(WORDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [CHAN_W-1:0]    in_chan,
    input  logic [NV_W-1:0]      in_nvalid,
    input  logic                 in_sob,
    input  logic                 in_eob,
    input  logic                 in_sop,
    input  logic [3:0]           in_eopcode,
    input  logic [CHAN_W-1:0]    q_chan,
    output logic                 q_open,
    output logic [NUM_CAUSE-1:0] err_flags,
    output logic [2:0]           err_cause
);
    logic                 burst_open, sop_prev, chan_open, active;
    logic [CHAN_W-1:0]    burst_chan;
    logic [NUM_CAUSE-1:0] viol;

    assign active = (in_nvalid != '0);

    bic_burst_track #(.CHAN_W(CHAN_W), .NV_W(NV_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .in_chan(in_chan), .in_nvalid(in_nvalid),
        .in_sob(in_sob), .in_eob(in_eob), .in_sop(in_sop), .in_eop(in_eopcode[3]),
        .burst_open(burst_open), .burst_chan(burst_chan), .sop_prev(sop_prev)
    );

    bic_chan_table #(.CHAN_W(CHAN_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_chan(in_chan),
        .set_en(active && in_sop), .clr_en(active && in_eopcode[3]),
        .rd_chan(in_chan), .rd_open(chan_open), .q_chan(q_chan), .q_open(q_open)
    );

    bic_rules #(.CHAN_W(CHAN_W), .NV_W(NV_W), .FULL(WORDS)) u_rules (
        .in_chan(in_chan), .in_nvalid(in_nvalid), .in_sob(in_sob), .in_eob(in_eob),
        .in_sop(in_sop), .in_eopcode(in_eopcode), .burst_open(burst_open),
        .burst_chan(burst_chan), .sop_prev(sop_prev), .chan_open(chan_open), .viol(viol)
    );

    bic_err_log u_log (
        .clk(clk), .rst_n(rst_n), .clr(clr), .viol(viol),
        .err_flags(err_flags), .err_cause(err_cause)
    );
endmodule

// File: rtl/bic_checker.sv
module bic_checker #(
    parameter int CHAN_W = 8,
    parameter int NV_W   = 3,
    parameter int FULL   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic [CHAN_W-1:0] in_chan,
    input logic [NV_W-1:0]   in_nvalid,
    input logic              in_sop,
    input logic              in_eob,
    input logic [3:0]        in_eopcode,
    input logic [CHAN_W-1:0] q_chan,
    input logic              q_open,
    input logic [6:0]        err_flags,
    input logic [2:0]        err_cause
);
    a_r4_sop_short: assert property (@(posedge clk) disable iff (!rst_n)
        (in_nvalid != '0 && in_sop && in_nvalid != NV_W'(FULL) && !clr) |=> err_flags[2]);

    a_r5_eop_needs_eob: assert property (@(posedge clk) disable iff (!rst_n)
        (in_nvalid != '0 && in_eopcode[3] && !in_eob && !clr) |=> err_flags[3]);

    a_r9_sop_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (in_nvalid != '0 && in_sop && !in_eopcode[3]) |=> (q_open || q_chan != $past(in_chan)));

    a_r10_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    a_r10_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cause != 3'd0 && !clr) |=> $stable(err_cause));

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (err_flags == '0 && err_cause == 3'd0));
endmodule

bind burst_iface_checker bic_checker #(.CHAN_W(CHAN_W), .NV_W(NV_W), .FULL(WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_chan(in_chan), .in_nvalid(in_nvalid),
    .in_sop(in_sop), .in_eob(in_eob), .in_eopcode(in_eopcode), .q_chan(q_chan),
    .q_open(q_open), .err_flags(err_flags), .err_cause(err_cause)
);

// File: tb/burst_iface_checker_tb.sv
module burst_iface_checker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic [7:0] in_chan = '0;
    logic [2:0] in_nvalid = '0;
    logic       in_sob = 1'b0, in_eob = 1'b0, in_sop = 1'b0;
    logic [3:0] in_eopcode = '0;
    logic [7:0] q_chan = '0;
    logic       q_open;
    logic [6:0] err_flags;
    logic [2:0] err_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0] f;
        logic [2:0] c;
        string      tag;
    } exp_t;
    exp_t sb[$];

    // bench model state
    bit       m_open[256];
    bit       m_bopen = 0;
    bit [7:0] m_bchan = 0;
    bit       m_sopp = 0;
    bit [6:0] m_f = 0;
    bit [2:0] m_c = 0;

    always #5 clk = ~clk;

    burst_iface_checker u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_chan(in_chan), .in_nvalid(in_nvalid),
        .in_sob(in_sob), .in_eob(in_eob), .in_sop(in_sop), .in_eopcode(in_eopcode),
        .q_chan(q_chan), .q_open(q_open), .err_flags(err_flags), .err_cause(err_cause)
    );

    task automatic cyc(input logic [7:0] ch, input logic [2:0] nv, input bit sob, input bit eob,
                       input bit sop, input logic [3:0] eo, input bit cl, input string tag);
        bit [6:0] v;
        bit act, full, op;
        exp_t e;
        @(negedge clk);
        in_chan = ch; in_nvalid = nv; in_sob = sob; in_eob = eob;
        in_sop = sop; in_eopcode = eo; clr = cl;
        act = (nv != 0); full = (nv == 3'd4); op = m_open[ch];
        v = '0;
        v[0] = act && !m_bopen && !sob;                        // R2
        v[1] = !act && (sob || eob || sop || eo != 0);          // R3
        v[2] = (act && sop && !full) || (m_sopp && !full);      // R4
        v[3] = act && eo[3] && !eob;                            // R5
        v[4] = act && m_bopen && (sob || ch != m_bchan);        // R6
        v[5] = act && sop && op;                                // R7
        v[6] = act && eo[3] && !sop && !op;                     // R8
        if (cl) begin
            m_f = 0; m_c = 0;
        end else begin
            if (m_c == 0) begin
                for (int k = 7; k >= 1; k--) if (v[k-1]) m_c = 3'(k);
            end
            m_f = m_f | v;
        end
        if (act && sob) begin m_bopen = 1; m_bchan = ch; end
        if (act && eob) m_bopen = 0;
        m_sopp = act && sop && !eo[3];
        if (act && sop) m_open[ch] = 1;
        if (act && eo[3]) m_open[ch] = 0;
        e.f = m_f; e.c = m_c; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #1;
        in_nvalid = '0; in_sob = 0; in_eob = 0; in_sop = 0; in_eopcode = '0; clr = 0;
    endtask

    task automatic chk_open(input logic [7:0] ch, input bit exp, input string tag);
        q_chan = ch;
        #1;
        checks++;
        if (q_open !== exp) begin
            errors++;
            $display("FAIL %s: q_open[%0d] actual %b expected %b", tag, ch, q_open, exp);
        end
    endtask

    // monitor: compare registered outputs after each driven edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (err_flags !== e.f || err_cause !== e.c) begin
                    errors++;
                    $display("FAIL %s: flags/cause actual %b/%0d expected %b/%0d",
                             e.tag, err_flags, err_cause, e.f, e.c);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (err_flags !== '0 || err_cause !== '0) begin
            errors++;
            $display("FAIL R1: flags/cause actual %b/%0d expected 0/0", err_flags, err_cause);
        end
        chk_open(8'd0, 0, "R1");
        chk_open(8'd255, 0, "R1");

        // R12 legal interleaving, R9 table tracking
        cyc(5, 4, 1, 0, 1, 4'b0000, 0, "R12");
        cyc(5, 4, 0, 0, 0, 4'b0000, 0, "R12");
        cyc(5, 4, 0, 1, 0, 4'b0000, 0, "R12");
        chk_open(8'd5, 1, "R9");
        cyc(9, 4, 1, 0, 1, 4'b0000, 0, "R12");
        cyc(9, 4, 0, 1, 0, 4'b1000, 0, "R12");
        chk_open(8'd9, 0, "R9");
        cyc(5, 4, 1, 0, 0, 4'b0000, 0, "R12");
        cyc(5, 2, 0, 1, 0, 4'b1011, 0, "R12");
        chk_open(8'd5, 0, "R9");
        cyc(3, 4, 1, 1, 1, 4'b1000, 0, "R9");
        chk_open(8'd3, 0, "R9");

        // R2 stray data, R11 clear
        cyc(0, 2, 0, 0, 0, 4'b0000, 0, "R2");
        cyc(0, 0, 0, 0, 0, 4'b0000, 1, "R11");

        // R3 flag without data
        cyc(0, 0, 0, 1, 0, 4'b0000, 0, "R3");
        cyc(0, 0, 0, 0, 0, 4'b0000, 1, "R11");

        // R4 start cycle and following cycle must be full
        cyc(1, 4, 1, 0, 1, 4'b0000, 0, "R4");
        cyc(1, 3, 0, 1, 0, 4'b0000, 0, "R4");
        cyc(0, 0, 0, 0, 0, 4'b0000, 1, "R11");
        cyc(2, 2, 1, 1, 1, 4'b0000, 0, "R4");
        cyc(0, 0, 0, 0, 0, 4'b0000, 1, "R11");
        cyc(1, 4, 1, 1, 0, 4'b1000, 0, "R4");
        cyc(2, 4, 1, 1, 0, 4'b1000, 0, "R4");

        // R5 end without burst end
        cyc(7, 4, 1, 0, 1, 4'b0000, 0, "R5");
        cyc(7, 4, 0, 1, 0, 4'b0000, 0, "R5");
        cyc(7, 4, 1, 0, 0, 4'b1000, 0, "R5");
        cyc(7, 1, 0, 1, 0, 4'b0000, 0, "R5");
        cyc(0, 0, 0, 0, 0, 4'b0000, 1, "R11");

        // R6 channel switch and restart inside a burst
        cyc(4, 4, 1, 0, 0, 4'b0000, 0, "R6");
        cyc(6, 4, 0, 0, 0, 4'b0000, 0, "R6");
        cyc(4, 4, 0, 1, 0, 4'b0000, 0, "R6");
        cyc(0, 0, 0, 0, 0, 4'b0000, 1, "R11");
        cyc(4, 4, 1, 0, 0, 4'b0000, 0, "R6");
        cyc(4, 4, 1, 1, 0, 4'b0000, 0, "R6");
        cyc(0, 0, 0, 0, 0, 4'b0000, 1, "R11");

        // R7 start on open channel
        cyc(10, 4, 1, 0, 1, 4'b0000, 0, "R7");
        cyc(10, 4, 0, 1, 0, 4'b0000, 0, "R7");
        cyc(10, 4, 1, 1, 1, 4'b0000, 0, "R7");
        cyc(10, 4, 1, 1, 0, 4'b1000, 0, "R7");
        chk_open(8'd10, 0, "R7");
        cyc(0, 0, 0, 0, 0, 4'b0000, 1, "R11");

        // R8 end on closed channel
        cyc(20, 4, 1, 1, 0, 4'b1000, 0, "R8");
        cyc(0, 0, 0, 0, 0, 4'b0000, 1, "R11");

        // R10 accumulation and first-cause priority
        cyc(0, 1, 0, 0, 0, 4'b0000, 0, "R10");
        cyc(0, 0, 0, 1, 0, 4'b0000, 0, "R10");
        cyc(0, 0, 0, 0, 0, 4'b0000, 1, "R11");
        cyc(30, 4, 1, 0, 0, 4'b1000, 0, "R10");
        cyc(30, 4, 0, 1, 0, 4'b0000, 0, "R10");
        cyc(0, 0, 0, 0, 0, 4'b0000, 1, "R11");

        // R11 clear discards same-cycle violation, leaves table intact
        cyc(0, 2, 0, 0, 0, 4'b0000, 1, "R11");
        cyc(40, 4, 1, 0, 1, 4'b0000, 0, "R11");
        cyc(40, 4, 0, 1, 0, 4'b0000, 0, "R11");
        cyc(0, 0, 0, 0, 0, 4'b0000, 1, "R11");
        chk_open(8'd40, 1, "R11");
        cyc(40, 4, 1, 1, 0, 4'b1000, 0, "R9");
        chk_open(8'd40, 0, "R9");

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule